// File: doc/BRIEF.md
# Mode-Aware Stack Pointer Control

This block follows the execution mode of a processor core (thread or handler) and keeps a two-bit control word. Bit 0 of that word sets the thread privilege level and bit 1 asks for the process stack. The block combines mode and control word into two outputs: the active-stack select and the current privilege state. The stack pointer registers sit elsewhere and use the select output to choose between the main and the process pointer.

Software reaches the control word through a write port and a read port. The block filters each write by mode and privilege, and it masks the stack bit on read while the core is in handler mode. Two strobes from the exception logic drive the mode state machine. An entry strobe moves the core into handler mode. A return strobe either leaves handler mode for thread mode, taking a supplied stack choice with it, or stays in handler mode for a nested return.

The state machine has two states. `MODE_THREAD` is the reset state. `MODE_HANDLER` runs every exception. There are five named transitions:
- `TR_TAKE_EXC`: thread to handler on an entry strobe.
- `TR_NEST_EXC`: handler to handler on an entry strobe.
- `TR_RET_THREAD`: handler to thread on a return strobe that targets thread mode.
- `TR_RET_NESTED`: handler to handler on a return strobe that targets handler mode.
- `TR_NONE`: the machine holds its state.

Top module: `spctl_top`

## Requirements
- R1: After reset the block is in thread mode with both control bits at 0, so `use_psp` is 0, `cur_priv` is 1, `in_handler` is 0 and `rd_data` is 0.
- R2: `use_psp` is 1 only when the mode is thread and stored bit 1 is 1; in handler mode it is always 0 (main stack).
- R3: `rd_data` bit 0 is the stored privilege bit and bit 1 is the stored stack bit in thread mode and 0 in handler mode; all bits above bit 1 read as 0.
- R4: In thread mode with bit 0 clear, a write (`sw_wr_en`=1) loads both control bits from `sw_wdata` on the next clock edge.
- R5: In thread mode with bit 0 set (unprivileged), a write changes neither control bit.
- R6: In handler mode a write loads bit 0 from `sw_wdata[0]` and ignores `sw_wdata[1]`.
- R7: An entry strobe places the block in handler mode on the next edge, clears bit 1 and keeps bit 0.
- R8: A return strobe with `ret_to_thread`=1 taken in handler mode returns the block to thread mode, loads bit 1 from `ret_spsel` and keeps bit 0.
- R9: A return strobe with `ret_to_thread`=0 in handler mode keeps handler mode and both bits; a return strobe seen in thread mode has no effect.
- R10: In one cycle an entry strobe takes precedence over a return strobe, and either strobe takes precedence over a software write, which is then dropped.
- R11: `cur_priv` is 1 when the block is in handler mode or bit 0 is 0, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_entry | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| ret_to_thread | input | 1 | Return target: 1 thread mode, 0 handler mode |
| ret_spsel | input | 1 | Stack bit restored on a return to thread mode |
| sw_wr_en | input | 1 | Software write request for the control word |
| sw_wdata | input | 2 | Write data: bit 1 stack, bit 0 privilege |
| rd_data | output | REG_W | Masked read-back of the control word |
| in_handler | output | 1 | 1 while in handler mode |
| use_psp | output | 1 | 1 selects the process stack, 0 the main stack |
| cur_priv | output | 1 | 1 when current execution is privileged |

## Verification
The assertions assume that the return strobe toward thread mode is only meaningful in handler mode, so the return properties are qualified by `in_handler`. They also assume the strobes are single-cycle pulses judged one edge at a time. The random stimulus raises the return strobe only while the reference model is in handler mode, so the return paths are always exercised from a legal state. A directed step then raises it in thread mode to show that it has no effect there. Entry, return and write requests are also forced into the same cycle on purpose, to exercise the precedence order.

// File: rtl/spctl_pkg.sv
package spctl_pkg;

    localparam int CTRL_W   = 2;
    localparam int PRIV_BIT = 0;
    localparam int SPSEL_BIT = 1;

    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } mode_e;

    typedef enum logic [2:0] {
        TR_NONE       = 3'd0,
        TR_TAKE_EXC   = 3'd1,
        TR_NEST_EXC   = 3'd2,
        TR_RET_THREAD = 3'd3,
        TR_RET_NESTED = 3'd4
    } trans_e;

    typedef struct packed {
        logic spsel;
        logic npriv;
    } ctrl_t;

endpackage

// File: rtl/spctl_mode_fsm.sv
module spctl_mode_fsm
    import spctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   exc_entry,
    input  logic   exc_return,
    input  logic   ret_to_thread,
    output mode_e  mode,
    output trans_e trans
);

    mode_e mode_q;
    mode_e mode_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_THREAD;
        end else begin
            mode_q <= mode_d;
        end
    end

    // transition selection and next state
    always_comb begin
        trans  = TR_NONE;
        mode_d = mode_q;
        unique case (mode_q)
            MODE_THREAD: begin
                if (exc_entry) begin
                    trans  = TR_TAKE_EXC;
                    mode_d = MODE_HANDLER;
                end
            end
            MODE_HANDLER: begin
                if (exc_entry) begin
                    trans  = TR_NEST_EXC;
                    mode_d = MODE_HANDLER;
                end else if (exc_return && ret_to_thread) begin
                    trans  = TR_RET_THREAD;
                    mode_d = MODE_THREAD;
                end else if (exc_return) begin
                    trans  = TR_RET_NESTED;
                    mode_d = MODE_HANDLER;
                end
            end
            default: begin
                trans  = TR_NONE;
                mode_d = MODE_THREAD;
            end
        endcase
    end

    assign mode = mode_q;

endmodule

// File: rtl/spctl_ctrl_reg.sv
module spctl_ctrl_reg
    import spctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  trans_e            trans,
    input  logic              ret_spsel,
    input  logic              sw_wr_en,
    input  logic [CTRL_W-1:0] sw_wdata,
    output ctrl_t             ctrl
);

    ctrl_t ctrl_q;
    ctrl_t ctrl_d;
    logic  wr_ok;

    // writes need privilege: handler mode or privilege bit clear
    assign wr_ok = sw_wr_en && ((mode == MODE_HANDLER) || !ctrl_q.npriv);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (trans)
            TR_TAKE_EXC, TR_NEST_EXC: begin
                ctrl_d.spsel = 1'b0;
            end
            TR_RET_THREAD: begin
                ctrl_d.spsel = ret_spsel;
            end
            TR_RET_NESTED: begin
                ctrl_d = ctrl_q;
            end
            TR_NONE: begin
                if (wr_ok) begin
                    ctrl_d.npriv = sw_wdata[PRIV_BIT];
                    if (mode == MODE_THREAD) begin
                        ctrl_d.spsel = sw_wdata[SPSEL_BIT];
                    end
                end
            end
            default: ctrl_d = ctrl_q;
        endcase
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/spctl_view.sv
module spctl_view
    import spctl_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  mode_e            mode,
    input  ctrl_t            ctrl,
    output logic [REG_W-1:0] rd_data,
    output logic             in_handler,
    output logic             use_psp,
    output logic             cur_priv
);

    localparam int PAD_W = REG_W - CTRL_W;

    logic is_thread;

    always_comb begin
        is_thread  = (mode == MODE_THREAD);
        in_handler = !is_thread;
        use_psp    = is_thread && ctrl.spsel;
        cur_priv   = !is_thread || !ctrl.npriv;
        rd_data    = {{PAD_W{1'b0}}, (is_thread && ctrl.spsel), ctrl.npriv};
    end

endmodule

// File: rtl/spctl_top.sv
module spctl_top
    import spctl_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_entry,
    input  logic              exc_return,
    input  logic              ret_to_thread,
    input  logic              ret_spsel,
    input  logic              sw_wr_en,
    input  logic [1:0]        sw_wdata,
    output logic [REG_W-1:0]  rd_data,
    output logic              in_handler,
    output logic              use_psp,
    output logic              cur_priv
);

    mode_e  mode;
    trans_e trans;
    ctrl_t  ctrl;

    spctl_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .exc_entry     (exc_entry),
        .exc_return    (exc_return),
        .ret_to_thread (ret_to_thread),
        .mode          (mode),
        .trans         (trans)
    );

    spctl_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .trans     (trans),
        .ret_spsel (ret_spsel),
        .sw_wr_en  (sw_wr_en),
        .sw_wdata  (sw_wdata),
        .ctrl      (ctrl)
    );

    spctl_view #(.REG_W(REG_W)) u_view (
        .mode       (mode),
        .ctrl       (ctrl),
        .rd_data    (rd_data),
        .in_handler (in_handler),
        .use_psp    (use_psp),
        .cur_priv   (cur_priv)
    );

endmodule

// File: rtl/spctl_top_chk.sv
module spctl_top_chk #(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exc_entry,
    input logic             exc_return,
    input logic             ret_to_thread,
    input logic             ret_spsel,
    input logic             sw_wr_en,
    input logic [REG_W-1:0] rd_data,
    input logic             in_handler,
    input logic             use_psp
);

    // R7
    entry_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> in_handler);

    // R7
    entry_priv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> (rd_data[0] == $past(rd_data[0])));

    // R2
    entry_main_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> !use_psp);

    // R5
    unpriv_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_en && !exc_entry && !in_handler && rd_data[0]) |=> $stable(rd_data));

    // R8
    ret_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && ret_to_thread && !exc_entry && in_handler)
        |=> (!in_handler && (use_psp == $past(ret_spsel))));

    // R9
    ret_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !ret_to_thread && in_handler) |=> (in_handler && $stable(rd_data)));

endmodule

bind spctl_top spctl_top_chk #(.REG_W(REG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .exc_entry     (exc_entry),
    .exc_return    (exc_return),
    .ret_to_thread (ret_to_thread),
    .ret_spsel     (ret_spsel),
    .sw_wr_en      (sw_wr_en),
    .rd_data       (rd_data),
    .in_handler    (in_handler),
    .use_psp       (use_psp)
);

// File: tb/spctl_top_test.sv
module spctl_top_test;

    localparam int REG_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             exc_entry = 1'b0;
    logic             exc_return = 1'b0;
    logic             ret_to_thread = 1'b0;
    logic             ret_spsel = 1'b0;
    logic             sw_wr_en = 1'b0;
    logic [1:0]       sw_wdata = 2'b00;
    logic [REG_W-1:0] rd_data;
    logic             in_handler;
    logic             use_psp;
    logic             cur_priv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    bit m_hand = 1'b0;
    bit m_b0 = 1'b0;
    bit m_b1 = 1'b0;

    always #5 clk = ~clk;

    spctl_top #(.REG_W(REG_W)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .exc_entry     (exc_entry),
        .exc_return    (exc_return),
        .ret_to_thread (ret_to_thread),
        .ret_spsel     (ret_spsel),
        .sw_wr_en      (sw_wr_en),
        .sw_wdata      (sw_wdata),
        .rd_data       (rd_data),
        .in_handler    (in_handler),
        .use_psp       (use_psp),
        .cur_priv      (cur_priv)
    );

    function automatic logic [REG_W-1:0] exp_rd();
        logic [REG_W-1:0] v = '0;
        v[0] = m_b0;
        v[1] = !m_hand && m_b1;
        return v;
    endfunction

    task automatic chk(string tag, logic [REG_W-1:0] act, logic [REG_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " R3 rd_data"}, rd_data, exp_rd());
        chk({tag, " R2 use_psp"}, REG_W'(use_psp), REG_W'(!m_hand && m_b1));
        chk({tag, " mode in_handler"}, REG_W'(in_handler), REG_W'(m_hand));
        chk({tag, " R11 cur_priv"}, REG_W'(cur_priv), REG_W'(m_hand || !m_b0));
    endtask

    // model of one clock edge
    task automatic model(bit en, bit rt, bit tt, bit rs, bit we, logic [1:0] wd);
        if (en) begin
            m_hand = 1'b1;
            m_b1 = 1'b0;
        end else if (rt && m_hand) begin
            if (tt) begin
                m_hand = 1'b0;
                m_b1 = rs;
            end
        end else if (we && (m_hand || !m_b0)) begin
            m_b0 = wd[0];
            if (!m_hand) m_b1 = wd[1];
        end
    endtask

    // drive at negedge, clock edge, check at following negedge
    task automatic step(string tag, bit en, bit rt, bit tt, bit rs, bit we, logic [1:0] wd);
        exc_entry = en;
        exc_return = rt;
        ret_to_thread = tt;
        ret_spsel = rs;
        sw_wr_en = we;
        sw_wdata = wd;
        model(en, rt, tt, rs, we, wd);
        @(negedge clk);
        exc_entry = 1'b0;
        exc_return = 1'b0;
        sw_wr_en = 1'b0;
        check_all(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // R4 privileged thread write selects process stack
        step("R4 write 10", 0, 0, 0, 0, 1, 2'b10);
        // R2 handler forces main stack; R7 entry clears bit1
        step("R7 entry", 1, 0, 0, 0, 0, 2'b00);
        // R6 handler write: bit0 loads, bit1 ignored
        step("R6 handler write", 0, 0, 0, 0, 1, 2'b11);
        // R9 nested return keeps state
        step("R9 nested return", 0, 1, 0, 1, 0, 2'b00);
        // R8 return to thread restores stack bit
        step("R8 return thread", 0, 1, 1, 1, 0, 2'b00);
        // R5 unprivileged write ignored
        step("R5 unpriv write", 0, 0, 0, 0, 1, 2'b00);
        // R9 return in thread mode has no effect
        step("R9 return in thread", 0, 1, 1, 0, 0, 2'b00);
        // R10 entry beats return and write
        step("R10 entry wins", 1, 1, 1, 1, 1, 2'b10);
        // R10 return beats write
        step("R10 return wins", 0, 1, 1, 0, 1, 2'b01);
        // R7 entry keeps bit0 = 1
        step("R7 entry keep priv", 1, 0, 0, 0, 0, 2'b00);
        step("R6 clear priv", 0, 0, 0, 0, 1, 2'b00);
        step("R8 return main", 0, 1, 1, 0, 0, 2'b00);
        step("R4 write 11", 0, 0, 0, 0, 1, 2'b11);

        for (int i = 0; i < 3000; i++) begin
            bit en;
            bit rt;
            bit we;
            en = ($urandom % 8) == 0;
            rt = m_hand && (($urandom % 4) == 0);
            we = ($urandom % 2) == 1;
            step("random R4 R5 R6 R7 R8 R9 R10", en, rt, 1'($urandom), 1'($urandom),
                 we, 2'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule